// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block models the write-command side of a parallel NOR flash that follows the common unlock-then-command protocol. A host on a simple synchronous bus presents a word address, a data byte and a write or read strobe each clock. The sequencer tracks the unlock pair and the command byte that follows it. It then programs single bytes, erases one sector or the whole array, and switches its read path between array data, status, identification codes and a query stub.

The storage is a small on-chip byte array. Erase fills the affected bytes with 0xFF in a single cycle. A separate down-counter then keeps the part busy for a parameterised number of cycles, and chip erase takes ten times as long as sector erase. A bypass mode lets the host program many bytes without repeating the unlock pair for each one.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block is in read-array mode, `busy_o` is low, every array byte reads 0xFF and the status byte is 0x80.
- R2: A command is accepted only after 0xAA written to address 0x555 and then 0x55 written to 0x2AA, with the command byte written to 0x555. Any mismatch returns the block to read-array mode and leaves the array unchanged.
- R3: When not busy, a write of 0xF0 returns the block to read-array mode from any cycle. The one exception is the data write that follows a program command, where 0xF0 is stored as data.
- R4: After command 0xA0, the next write stores its data byte at the byte the address selects (low `MEM_AW` bits). The status byte becomes {~data[7], 7'b0}, and the block returns to read-array mode.
- R5: Command 0x20 enters bypass mode, which stays in the command cycle. In bypass, commands are accepted at any address, and after each program the block returns to the command cycle. Reads outside read-array mode, autoselect and query return the status byte.
- R6: In bypass, command 0x90 followed by a write of 0x00 leaves bypass and returns to read-array mode.
- R7: After command 0x90 (autoselect), a read at address 0 returns `MFR_ID`, a read at address 1 returns `DEV_ID`, and reads at other addresses return 0x00. A write of 0x98 to address 0x055 enters query mode, and any other write returns to read-array mode.
- R8: In query mode every read returns `CFI_STUB`, and any write returns to read-array mode.
- R9: After command 0x80, the fourth write must be 0xAA to 0x555 and the fifth must be 0x55 to 0x2AA. Otherwise the block returns to read-array mode and nothing is erased.
- R10: On the sixth write, 0x10 to address 0x555 sets every array byte to 0xFF. 0x10 to any other address returns to read-array mode without erasing.
- R11: On the sixth write, 0x30 at any address sets every byte of the 2^`SECT_AW`-byte sector containing that address to 0xFF. All other bytes are left unchanged.
- R12: `busy_o` is high for exactly `SECT_ERASE_CYC` cycles after a sector-erase write and 10×`SECT_ERASE_CYC` cycles after a chip-erase write. While it is high, reads return 0x00 and every write, including 0xF0, is ignored.
- R13: When busy ends, the block is in read-array mode with bypass cleared.
- R14: `rdata_o` is loaded at each clock edge where `re_i` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 8 | Write data / command byte |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| busy_o | output | 1 | Erase in progress |

## Verification
A wrong sequencer phase appears at the next read as the wrong source: array data where status should be, or an ID where array data should be. It also appears one write later, when a program or erase lands or fails to land. A stuck or miscounted erase timer shows on `busy_o` within a cycle of the expected edge. A missing bypass clear shows as a program without unlock that takes effect after the erase ends. The bench keeps a behavioural model of phase, bypass, status and array, and compares `busy_o` and `rdata_o` with it after every clock.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [2:0] {
    PH_READ  = 3'd0,
    PH_UNLK  = 3'd1,
    PH_CMD   = 3'd2,
    PH_ARG   = 3'd3,
    PH_EKEY  = 3'd4,
    PH_ESEL  = 3'd5,
    PH_ERASE = 3'd6,
    PH_CFI   = 3'd7
  } phase_e;

  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_AUTOSEL = 8'h90;
  localparam logic [7:0] CMD_BYPASS  = 8'h20;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECT    = 8'h30;
  localparam logic [7:0] CMD_CFI     = 8'h98;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] KEY_A       = 8'hAA;
  localparam logic [7:0] KEY_B       = 8'h55;
  localparam logic [7:0] STAT_READY  = 8'h80;

  localparam logic [10:0] ADR_A   = 11'h555;
  localparam logic [10:0] ADR_B   = 11'h2AA;
  localparam logic [10:0] ADR_CFI = 11'h055;
endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              done_i,
  output phase_e            phase_o,
  output logic [7:0]        cmd_o,
  output logic [7:0]        status_o,
  output logic              prog_o,
  output logic              erase_chip_o,
  output logic              erase_sect_o
);
  phase_e     phase_q, phase_d;
  logic [7:0] cmd_q, cmd_d, stat_q, stat_d;
  logic       byp_q, byp_d, go_rst;
  logic       at_a, at_b, at_cfi;

  assign at_a   = addr_i == ADDR_W'(ADR_A);
  assign at_b   = addr_i == ADDR_W'(ADR_B);
  assign at_cfi = addr_i == ADDR_W'(ADR_CFI);

  always_comb begin
    phase_d      = phase_q;
    cmd_d        = cmd_q;
    byp_d        = byp_q;
    stat_d       = stat_q;
    prog_o       = 1'b0;
    erase_chip_o = 1'b0;
    erase_sect_o = 1'b0;
    go_rst       = 1'b0;
    if (phase_q == PH_ERASE) begin
      if (done_i) begin
        go_rst = 1'b1;
        stat_d = STAT_READY;
      end
    end else if (we_i) begin
      if (wdata_i == CMD_RESET && !(phase_q == PH_ARG && cmd_q == CMD_PROG)) begin
        go_rst = 1'b1;
      end else begin
        case (phase_q)
          PH_READ: if (at_a && wdata_i == KEY_A) phase_d = PH_UNLK;
          PH_UNLK: if (at_b && wdata_i == KEY_B) phase_d = PH_CMD; else go_rst = 1'b1;
          PH_CMD: begin
            if (byp_q || at_a) begin
              case (wdata_i)
                CMD_PROG, CMD_ERASE, CMD_AUTOSEL: begin
                  phase_d = PH_ARG;
                  cmd_d   = wdata_i;
                end
                CMD_BYPASS: begin
                  byp_d = 1'b1;
                  cmd_d = '0;
                end
                default: go_rst = 1'b1;
              endcase
            end else go_rst = 1'b1;
          end
          PH_ARG: begin
            case (cmd_q)
              CMD_PROG: begin
                prog_o = 1'b1;
                stat_d = {~wdata_i[7], 7'b0};
                if (byp_q) begin
                  phase_d = PH_CMD;
                  cmd_d   = '0;
                end else go_rst = 1'b1;
              end
              CMD_AUTOSEL: begin
                if (!(byp_q && wdata_i == 8'h00) && at_cfi && wdata_i == CMD_CFI)
                  phase_d = PH_CFI;
                else go_rst = 1'b1;
              end
              CMD_ERASE: if (at_a && wdata_i == KEY_A) phase_d = PH_EKEY; else go_rst = 1'b1;
              default: go_rst = 1'b1;
            endcase
          end
          PH_EKEY: if (at_b && wdata_i == KEY_B) phase_d = PH_ESEL; else go_rst = 1'b1;
          PH_ESEL: begin
            if (wdata_i == CMD_CHIP && at_a) begin
              erase_chip_o = 1'b1;
              stat_d       = '0;
              phase_d      = PH_ERASE;
              cmd_d        = wdata_i;
            end else if (wdata_i == CMD_SECT) begin
              erase_sect_o = 1'b1;
              stat_d       = '0;
              phase_d      = PH_ERASE;
              cmd_d        = wdata_i;
            end else go_rst = 1'b1;
          end
          default: go_rst = 1'b1;
        endcase
      end
    end
    if (go_rst) begin
      phase_d = PH_READ;
      cmd_d   = '0;
      byp_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_READ;
      cmd_q   <= '0;
      byp_q   <= 1'b0;
      stat_q  <= STAT_READY;
    end else begin
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      byp_q   <= byp_d;
      stat_q  <= stat_d;
    end
  end

  assign phase_o  = phase_q;
  assign cmd_o    = cmd_q;
  assign status_o = stat_q;
endmodule

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
  parameter int SECT_CYC = 16,
  parameter int CHIP_CYC = 160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_chip_i,
  input  logic start_sect_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CHIP_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_chip_i)    cnt_q <= CNT_W'(CHIP_CYC);
    else if (start_sect_i)    cnt_q <= CNT_W'(SECT_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = cnt_q != '0;
  assign done_o = cnt_q == CNT_W'(1);
endmodule

// File: rtl/nor_seq_array.sv
module nor_seq_array #(
  parameter int MEM_AW  = 8,
  parameter int SECT_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              prog_i,
  input  logic              erase_chip_i,
  input  logic              erase_sect_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int SIDX_W = MEM_AW - SECT_AW;

  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    logic hit_sect;
    assign hit_sect = addr_i[MEM_AW-1:SECT_AW] == SIDX_W'(i >> SECT_AW);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem[i] <= 8'hFF;
      else if (erase_chip_i || (erase_sect_i && hit_sect)) mem[i] <= 8'hFF;
      else if (prog_i && addr_i == MEM_AW'(i))          mem[i] <= wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int         ADDR_W         = 11,
  parameter int         MEM_AW         = 8,
  parameter int         SECT_AW        = 5,
  parameter int         SECT_ERASE_CYC = 16,
  parameter logic [7:0] MFR_ID         = 8'h01,
  parameter logic [7:0] DEV_ID         = 8'h7E,
  parameter logic [7:0] CFI_STUB       = 8'h51
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o
);
  localparam int CHIP_ERASE_CYC = 10 * SECT_ERASE_CYC;

  phase_e     phase;
  logic [7:0] cmd, status, mem_rd, id_rd, rd_d;
  logic       prog, e_chip, e_sect, done, busy;

  nor_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .done_i(done), .phase_o(phase), .cmd_o(cmd), .status_o(status),
    .prog_o(prog), .erase_chip_o(e_chip), .erase_sect_o(e_sect)
  );

  nor_seq_timer #(.SECT_CYC(SECT_ERASE_CYC), .CHIP_CYC(CHIP_ERASE_CYC)) u_timer (
    .clk_i, .rst_ni, .start_chip_i(e_chip), .start_sect_i(e_sect),
    .busy_o(busy), .done_o(done)
  );

  nor_seq_array #(.MEM_AW(MEM_AW), .SECT_AW(SECT_AW)) u_array (
    .clk_i, .rst_ni, .addr_i(addr_i[MEM_AW-1:0]), .wdata_i,
    .prog_i(prog), .erase_chip_i(e_chip), .erase_sect_i(e_sect), .rdata_o(mem_rd)
  );

  assign id_rd = (addr_i[ADDR_W-1:1] != '0) ? 8'h00 : (addr_i[0] ? DEV_ID : MFR_ID);

  always_comb begin
    if (busy) rd_d = 8'h00;
    else begin
      case (phase)
        PH_READ: rd_d = mem_rd;
        PH_CFI:  rd_d = CFI_STUB;
        PH_ARG:  rd_d = (cmd == CMD_AUTOSEL) ? id_rd : status;
        default: rd_d = status;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_d;
  end

  assign busy_o = busy;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
  import nor_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic       re_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       busy_o,
  input phase_e     phase_i,
  input logic [7:0] cmd_i
);
  a_r12_busy_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && busy_o |=> rdata_o == 8'h00);

  a_r12_busy_in_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> phase_i == PH_ERASE);

  a_r12_writes_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && we_i |=> phase_i == PH_ERASE || phase_i == PH_READ);

  a_r13_erase_end_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> phase_i == PH_READ);

  a_r3_abort_to_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wdata_i == CMD_RESET && !busy_o && !(phase_i == PH_ARG && cmd_i == CMD_PROG)
    |=> phase_i == PH_READ);

  a_r8_query_write_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && phase_i == PH_CFI |=> phase_i == PH_READ);

  a_r11_sector_goes_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && phase_i == PH_ESEL && wdata_i == CMD_SECT |=> busy_o);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .busy_o(busy_o), .phase_i(phase), .cmd_i(cmd)
);

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;
  localparam int AW = 11, MAW = 8, SAW = 5, SECT = 16, CHIP = 160;
  localparam logic [7:0] MFR = 8'h01, DEV = 8'h7E, STUB = 8'h51;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic [7:0]    wdata, rdata;
  logic          we, re, busy;

  nor_cmd_seq #(.ADDR_W(AW), .MEM_AW(MAW), .SECT_AW(SAW), .SECT_ERASE_CYC(SECT),
                .MFR_ID(MFR), .DEV_ID(DEV), .CFI_STUB(STUB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .busy_o(busy)
  );

  int checks = 0, fails = 0;

  // behavioural reference
  logic [7:0] m_mem [256];
  int         ph, m_busy;
  logic [7:0] m_cmd, m_stat, m_rd;
  bit         m_byp;

  function automatic void m_reset();
    ph = 0; m_cmd = 0; m_byp = 0;
  endfunction

  function automatic logic [7:0] m_read(logic [10:0] a);
    if (m_busy > 0) return 8'h00;
    if (ph == 7) return STUB;
    if (ph == 3 && m_cmd == 8'h90) return (a > 1) ? 8'h00 : (a[0] ? DEV : MFR);
    if (ph != 0) return m_stat;
    return m_mem[a[7:0]];
  endfunction

  function automatic void m_write(logic [10:0] a, logic [7:0] d);
    if (d == 8'hF0 && !(ph == 3 && m_cmd == 8'hA0)) begin m_reset(); return; end
    case (ph)
      0: if (a == 11'h555 && d == 8'hAA) ph = 1;
      1: if (a == 11'h2AA && d == 8'h55) ph = 2; else m_reset();
      2: if (m_byp || a == 11'h555) begin
           if (d == 8'hA0 || d == 8'h80 || d == 8'h90) begin ph = 3; m_cmd = d; end
           else if (d == 8'h20) begin m_byp = 1; m_cmd = 0; end
           else m_reset();
         end else m_reset();
      3: if (m_cmd == 8'hA0) begin
           m_mem[a[7:0]] = d; m_stat = {~d[7], 7'b0};
           if (m_byp) begin ph = 2; m_cmd = 0; end else m_reset();
         end else if (m_cmd == 8'h90) begin
           if (!(m_byp && d == 0) && a == 11'h055 && d == 8'h98) ph = 7; else m_reset();
         end else begin
           if (a == 11'h555 && d == 8'hAA) ph = 4; else m_reset();
         end
      4: if (a == 11'h2AA && d == 8'h55) ph = 5; else m_reset();
      5: if (d == 8'h10 && a == 11'h555) begin
           for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
           m_stat = 0; m_busy = CHIP; ph = 6; m_cmd = d;
         end else if (d == 8'h30) begin
           for (int i = 0; i < 32; i++) m_mem[{a[7:5], 5'b0} + i] = 8'hFF;
           m_stat = 0; m_busy = SECT; ph = 6; m_cmd = d;
         end else m_reset();
      default: m_reset();
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit w, bit r, logic [10:0] a, logic [7:0] d, string tag);
    we = w; re = r; addr = a; wdata = d;
    if (r) m_rd = m_read(a);
    if (m_busy > 0) begin
      m_busy--;
      if (m_busy == 0) begin m_reset(); m_stat = 8'h80; end
    end else if (w) m_write(a, d);
    @(posedge clk); #1;
    chk(r ? tag : "R14", rdata, m_rd);
    chk("R12", {7'b0, busy}, {7'b0, m_busy > 0});
    @(negedge clk);
    we = 0; re = 0;
  endtask

  task automatic wr(logic [10:0] a, logic [7:0] d, string tag);
    step(1, 0, a, d, tag);
  endtask
  task automatic rd(logic [10:0] a, string tag);
    step(0, 1, a, 8'h00, tag);
  endtask
  task automatic unlock();
    wr(11'h555, 8'hAA, "R2"); wr(11'h2AA, 8'h55, "R2");
  endtask
  task automatic wait_idle(string tag);
    while (m_busy > 0) step(0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
    m_stat = 8'h80; m_rd = 0; m_busy = 0; m_reset();
    rst_n = 0; we = 0; re = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(11'h000, "R1"); rd(11'h0FF, "R1"); rd(11'h555, "R1");
    // R4 program
    unlock(); wr(11'h555, 8'hA0, "R4"); wr(11'h010, 8'h5A, "R4");
    rd(11'h010, "R4"); rd(11'h011, "R4");
    // R4: 0xF0 is data in the program cycle
    unlock(); wr(11'h555, 8'hA0, "R4"); wr(11'h012, 8'hF0, "R4"); rd(11'h012, "R4");
    // R2 mismatches
    wr(11'h555, 8'hAA, "R2"); wr(11'h2AA, 8'h54, "R2"); wr(11'h555, 8'hA0, "R2");
    wr(11'h020, 8'h11, "R2"); rd(11'h020, "R2");
    unlock(); wr(11'h554, 8'hA0, "R2"); wr(11'h021, 8'h3C, "R2"); rd(11'h021, "R2");
    wr(11'h556, 8'hAA, "R2"); wr(11'h2AA, 8'h55, "R2"); rd(11'h000, "R2");
    // R3 abort mid-sequence
    wr(11'h555, 8'hAA, "R3"); wr(11'h000, 8'hF0, "R3");
    wr(11'h2AA, 8'h55, "R3"); wr(11'h555, 8'hA0, "R3"); wr(11'h022, 8'h00, "R3");
    rd(11'h022, "R3");
    unlock(); rd(11'h000, "R3"); wr(11'h123, 8'hF0, "R3"); rd(11'h010, "R3");
    // R5 bypass with status
    unlock(); wr(11'h555, 8'h20, "R5"); rd(11'h000, "R5");
    wr(11'h077, 8'hA0, "R5"); wr(11'h030, 8'h12, "R5"); rd(11'h030, "R5");
    wr(11'h3FF, 8'hA0, "R5"); wr(11'h031, 8'h93, "R5"); rd(11'h031, "R5");
    // R6 bypass exit
    wr(11'h100, 8'h90, "R6"); wr(11'h101, 8'h00, "R6");
    rd(11'h031, "R6"); rd(11'h030, "R6");
    wr(11'h000, 8'hA0, "R6"); wr(11'h032, 8'h44, "R6"); rd(11'h032, "R6");
    // R7 autoselect, R8 query
    unlock(); wr(11'h555, 8'h90, "R7");
    rd(11'h000, "R7"); rd(11'h001, "R7"); rd(11'h005, "R7");
    wr(11'h055, 8'h98, "R7"); rd(11'h000, "R8"); rd(11'h2AA, "R8");
    wr(11'h000, 8'h00, "R8"); rd(11'h010, "R8");
    unlock(); wr(11'h555, 8'h90, "R7"); wr(11'h054, 8'h98, "R7"); rd(11'h010, "R7");
    // R9 erase unlock mismatch
    unlock(); wr(11'h555, 8'h80, "R9"); wr(11'h555, 8'hAA, "R9"); wr(11'h2AA, 8'h56, "R9");
    wr(11'h555, 8'h30, "R9"); rd(11'h030, "R9");
    unlock(); wr(11'h555, 8'h80, "R9"); wr(11'h554, 8'hAA, "R9"); rd(11'h010, "R9");
    // R11 sector erase, R12 busy behaviour
    unlock(); wr(11'h555, 8'h80, "R11"); unlock(); wr(11'h03B, 8'h30, "R11");
    rd(11'h010, "R12"); wr(11'h000, 8'hF0, "R12");
    wr(11'h555, 8'hAA, "R12"); wr(11'h2AA, 8'h55, "R12"); wr(11'h555, 8'hA0, "R12");
    wr(11'h011, 8'h00, "R12");
    wait_idle("R12");
    rd(11'h031, "R11"); rd(11'h030, "R11"); rd(11'h010, "R11"); rd(11'h011, "R12");
    // R13 bypass cleared by erase end
    unlock(); wr(11'h555, 8'h20, "R13"); wr(11'h000, 8'hA0, "R13"); wr(11'h0C1, 8'h07, "R13");
    wr(11'h000, 8'h80, "R13"); unlock(); wr(11'h0C0, 8'h30, "R13");
    wait_idle("R12");
    rd(11'h0C1, "R13");
    wr(11'h000, 8'hA0, "R13"); wr(11'h000, 8'h11, "R13"); rd(11'h000, "R13");
    // R10 chip erase
    unlock(); wr(11'h555, 8'h80, "R10"); unlock(); wr(11'h554, 8'h10, "R10");
    rd(11'h010, "R10"); rd(11'h000, "R10");
    unlock(); wr(11'h555, 8'h80, "R10"); unlock(); wr(11'h555, 8'h10, "R10");
    rd(11'h010, "R12");
    wait_idle("R12");
    rd(11'h010, "R10"); rd(11'h032, "R10"); rd(11'h012, "R10");
    summary();
    $finish;
  end
endmodule